// File: doc/BRIEF.md
# Dual-Lane Serial Bit-Rate Tick Generator

This block paces the transmit and receive halves of an asynchronous serial port. It turns the master clock into a base step. The step comes from one of three fixed prescaler taps or from an external timer pulse. Two independent lanes divide that step down into single-cycle bit-rate enables, one for transmit and one for receive. Each lane has a 5-bit counter that is compared against a programmable divisor. Every match reloads the counter and toggles a half-rate flag, and every second match emits a tick.

The two lanes are gated differently. The transmit lane runs whenever power and transmit-enable are both set. It is re-phased once, on the first buffer load after it is enabled, so that the first bit boundary lines up with the data. The receive lane waits idle for a start-bit strobe, runs through one frame, and stops on a frame-done strobe. All controls are plain level or strobe pins. There is no data stream and so no handshake. Every output is an enable in the master clock domain, never a derived clock.

Top module: `baud_gen_dual`

## Requirements
- R1: `src_sel_i` picks the base step. The code 0 gives one step every 2 master cycles, 1 gives one every 8, 2 gives one every 32, and 3 selects the external pulse.
- R2: With code 3, each rising edge of `ext_pulse_i` is synchronised and gives exactly one base step, so the tick spacing equals 2×(divisor+1) external pulse periods.
- R3: While `power_i` is 0, neither `tx_tick_o` nor `rx_tick_o` pulses. The effect starts from the second cycle after power falls.
- R4: A running lane ticks every 2×(divisor+1) base steps.
- R5: The transmit lane is held at zero and gives no ticks unless both `power_i` and `tx_en_i` are 1. The receive lane is unaffected by `tx_en_i`.
- R6: The first `tx_load_i` strobe after the transmit lane is enabled clears its counter. The next transmit tick then follows after 2×(divisor+1) base steps, which is 4×(divisor+1)−1 or 4×(divisor+1) cycles with code 0.
- R7: Later `tx_load_i` strobes, while the lane stays enabled, have no effect on tick timing.
- R8: With power and `rx_en_i` set, the receive lane gives no ticks until `rx_start_i` pulses. From that strobe its first tick follows with the same latency as in R6.
- R9: `rx_done_i` returns the receive lane to idle. No receive tick appears from the second cycle after it. A `rx_start_i` strobe while the lane is already running has no effect.
- R10: A divisor below 8 holds both counters and suppresses all ticks.
- R11: Each tick is high for exactly one master cycle, and both outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pulse_i | input | 1 | External timer pulse, asynchronous |
| power_i | input | 1 | Block power control |
| tx_en_i | input | 1 | Transmit lane enable |
| rx_en_i | input | 1 | Receive lane enable |
| src_sel_i | input | 2 | Base step source select |
| divisor_i | input | 5 | Match value shared by both lanes |
| tx_load_i | input | 1 | Transmit buffer load strobe |
| rx_start_i | input | 1 | Start bit detected strobe |
| rx_done_i | input | 1 | Frame received strobe |
| tx_tick_o | output | 1 | Transmit bit-rate enable pulse |
| rx_tick_o | output | 1 | Receive bit-rate enable pulse |

## Verification
A strobe is sampled at edge E0, and the clear or start takes effect at that edge. The first tick then registers at the edge that ends the 2×(divisor+1)-th base step. With the fastest tap this is E0+4×(divisor+1)−1 or E0+4×(divisor+1), depending on the free-running prescaler phase, so the latency checks accept exactly that two-cycle window. Tick spacing is checked as an exact cycle count between consecutive pulses, and the first pulse after any configuration change is discarded. Checks for silence start sampling two cycles after a disabling input, because a tick already registered at the disabling edge is still allowed to appear. Every output is read on the falling edge.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SRC_TAP_A = 2'd0,
    SRC_TAP_B = 2'd1,
    SRC_TAP_C = 2'd2,
    SRC_EXT   = 2'd3
  } src_sel_e;

  localparam int unsigned LANE_TX = 0;
  localparam int unsigned LANE_RX = 1;
  localparam int unsigned N_LANES = 2;
endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel
  import baud_pkg::*;
#(
  parameter int unsigned RATIO_A     = 2,
  parameter int unsigned RATIO_B     = 8,
  parameter int unsigned RATIO_C     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       power_i,
  input  logic [1:0] sel_i,
  input  logic       ext_i,
  output logic       step_o
);
  localparam int unsigned PRE_W = $clog2(RATIO_C);
  localparam logic [PRE_W-1:0] MASK_A = PRE_W'(RATIO_A - 1);
  localparam logic [PRE_W-1:0] MASK_B = PRE_W'(RATIO_B - 1);
  localparam logic [PRE_W-1:0] MASK_C = PRE_W'(RATIO_C - 1);

  logic [PRE_W-1:0]       pre_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_q;
  logic                   ext_edge;
  src_sel_e               sel_e;

  assign sel_e = src_sel_e'(sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sync_q <= '0;
      ext_q  <= 1'b0;
    end else begin
      pre_q  <= power_i ? pre_q + 1'b1 : '0;
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      ext_q  <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_edge = sync_q[SYNC_STAGES-1] & ~ext_q;

  always_comb begin
    unique case (sel_e)
      SRC_TAP_A: step_o = power_i & ((pre_q & MASK_A) == MASK_A);
      SRC_TAP_B: step_o = power_i & ((pre_q & MASK_B) == MASK_B);
      SRC_TAP_C: step_o = power_i & ((pre_q & MASK_C) == MASK_C);
      default:   step_o = power_i & ext_edge;
    endcase
  end

  // R2: one external edge yields a single step cycle
  assert_ext_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);
endmodule

// File: rtl/baud_lane.sv
module baud_lane #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned MIN_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             half_q;
  logic             div_ok;
  logic             active;

  assign div_ok = (div_i >= CNT_W'(MIN_DIV));
  assign active = run_i & div_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      tick_o <= 1'b0;
    end else if (!active || clr_i) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (step_i) begin
        if (cnt_q == div_i) begin
          cnt_q  <= '0;
          half_q <= ~half_q;
          tick_o <= half_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R11: pulses last one cycle
  assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R10: an out-of-range divisor keeps the lane silent
  assert_bad_div_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ok |=> !tick_o);
  // R5 / R8: a stopped lane rests at zero
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0) && !half_q);
endmodule

// File: rtl/baud_gen_dual.sv
module baud_gen_dual
  import baud_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned MIN_DIV = 8,
  parameter int unsigned RATIO_A = 2,
  parameter int unsigned RATIO_B = 8,
  parameter int unsigned RATIO_C = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pulse_i,
  input  logic             power_i,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic [1:0]       src_sel_i,
  input  logic [CNT_W-1:0] divisor_i,
  input  logic             tx_load_i,
  input  logic             rx_start_i,
  input  logic             rx_done_i,
  output logic             tx_tick_o,
  output logic             rx_tick_o
);
  logic               step;
  logic               tx_live, rx_live;
  logic               tx_primed_q, rx_busy_q;
  logic [N_LANES-1:0] lane_run, lane_clr, lane_tick;

  assign tx_live = power_i & tx_en_i;
  assign rx_live = power_i & rx_en_i;

  baud_src_sel #(
    .RATIO_A(RATIO_A), .RATIO_B(RATIO_B), .RATIO_C(RATIO_C), .SYNC_STAGES(2)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .power_i(power_i), .sel_i(src_sel_i),
    .ext_i(ext_pulse_i), .step_o(step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_primed_q <= 1'b0;
      rx_busy_q   <= 1'b0;
    end else begin
      if (!tx_live)       tx_primed_q <= 1'b0;
      else if (tx_load_i) tx_primed_q <= 1'b1;
      if (!rx_live)        rx_busy_q <= 1'b0;
      else if (rx_start_i) rx_busy_q <= 1'b1;
      else if (rx_done_i)  rx_busy_q <= 1'b0;
    end
  end

  assign lane_run[LANE_TX] = tx_live;
  assign lane_clr[LANE_TX] = tx_live & tx_load_i & ~tx_primed_q;
  assign lane_run[LANE_RX] = rx_live & rx_busy_q;
  assign lane_clr[LANE_RX] = 1'b0;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    baud_lane #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_lane (
      .clk(clk), .rst_n(rst_n), .step_i(step), .run_i(lane_run[g]),
      .clr_i(lane_clr[g]), .div_i(divisor_i), .tick_o(lane_tick[g])
    );
  end

  assign tx_tick_o = lane_tick[LANE_TX];
  assign rx_tick_o = lane_tick[LANE_RX];

  // R3: power off silences both outputs
  assert_power_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !power_i |=> !tx_tick_o && !rx_tick_o);
  // R5: transmit needs both controls
  assert_tx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |=> !tx_tick_o);
  // R8: receive lane silent while not in a frame
  assert_rx_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_busy_q |=> !rx_tick_o);
  // R9: frame done ends the frame unless a start coincides
  assert_rx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && !rx_start_i) |=> !rx_busy_q);
endmodule

// File: tb/sim_baud_gen_dual.sv
module sim_baud_gen_dual;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_pulse = 1'b0;
  logic power = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [4:0] divv = 5'd10;
  logic tx_load = 1'b0, rx_start = 1'b0, rx_done = 1'b0;
  logic tx_tick, rx_tick;

  int n_chk = 0, n_bad = 0, dbl = 0;
  int ext_per = 0;
  bit finished = 1'b0;
  logic prev_tx = 1'b0, prev_rx = 1'b0;

  always #10 clk = ~clk;

  baud_gen_dual u0 (
    .clk(clk), .rst_n(rst_n), .ext_pulse_i(ext_pulse), .power_i(power),
    .tx_en_i(tx_en), .rx_en_i(rx_en), .src_sel_i(sel), .divisor_i(divv),
    .tx_load_i(tx_load), .rx_start_i(rx_start), .rx_done_i(rx_done),
    .tx_tick_o(tx_tick), .rx_tick_o(rx_tick)
  );

  always @(negedge clk) begin
    if ((tx_tick && prev_tx) || (rx_tick && prev_rx)) dbl++;
    prev_tx <= tx_tick;
    prev_rx <= rx_tick;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (ext_per >= 4) begin
        ext_pulse = 1'b1;
        repeat (2) @(negedge clk);
        ext_pulse = 1'b0;
        repeat (ext_per - 3) @(negedge clk);
      end
    end
  end

  function automatic int ratio(input int s, input int per);
    case (s)
      0: ratio = 2;
      1: ratio = 8;
      2: ratio = 32;
      default: ratio = per;
    endcase
  endfunction

  function automatic int period(input int d, input int s, input int per);
    period = 2 * (d + 1) * ratio(s, per);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input bit rx, input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if ((rx ? rx_tick : tx_tick) === 1'b1) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic quiet(input bit rx, input int cycles, input string req);
    int cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if ((rx ? rx_tick : tx_tick) === 1'b1) cnt++;
    end
    check(cnt == 0, req, cnt, 0);
  endtask

  task automatic spacing(input bit rx, input int exp, input string req);
    int n;
    wait_tick(rx, 3 * exp + 200, n);
    for (int k = 0; k < 2; k++) begin
      wait_tick(rx, 2 * exp, n);
      check(n == exp, req, n, exp);
    end
  endtask

  task automatic pulse_load();
    tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic pulse_start();
    rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
  endtask

  task automatic restart_tx();
    tx_en = 1'b0; repeat (3) @(negedge clk); tx_en = 1'b1;
  endtask

  initial begin
    int n, d, s, p, lo;
    void'($urandom(32'h5eed_0b1d));
    repeat (5) @(negedge clk);
    check(tx_tick === 1'b0 && rx_tick === 1'b0, "R11 reset", int'(tx_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: unpowered, everything else enabled
    tx_en = 1'b1; rx_en = 1'b1; divv = 5'd8; sel = 2'd0;
    pulse_start(); pulse_load();
    quiet(1'b0, 300, "R3 tx");
    quiet(1'b1, 50, "R3 rx");

    // R1 / R4: directed boundary and random configurations
    power = 1'b1;
    for (int t = 0; t < 9; t++) begin
      if (t < 3) begin s = t; d = (t == 2) ? 8 : 31 - 10 * t; end
      else begin s = $urandom_range(0, 2); d = $urandom_range(8, 31); end
      if (s == 2 && d > 20) d = 20;
      sel = 2'(s); divv = 5'(d);
      restart_tx();
      spacing(1'b0, period(d, s, 0), (t < 3) ? "R1 tap" : "R4 spacing");
    end

    // R5: transmit disabled, receive still running
    sel = 2'd0; divv = 5'd12;
    tx_en = 1'b0;
    pulse_start();
    @(negedge clk);
    quiet(1'b0, 200, "R5 tx off");
    spacing(1'b1, period(12, 0, 0), "R5 rx unaffected");
    power = 1'b0; @(negedge clk); @(negedge clk);
    quiet(1'b1, 200, "R3 power drop");
    power = 1'b1;

    // R10: invalid divisors
    tx_en = 1'b1;
    divv = 5'd7; pulse_start(); @(negedge clk);
    quiet(1'b0, 300, "R10 div7 tx");
    quiet(1'b1, 100, "R10 div7 rx");
    divv = 5'd0;
    quiet(1'b0, 100, "R10 div0");
    rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;

    // R6 / R7: first load re-phases, later loads ignored
    for (int t = 0; t < 3; t++) begin
      d = $urandom_range(8, 31); sel = 2'd0; divv = 5'(d);
      p = period(d, 0, 0);
      restart_tx();
      repeat ($urandom_range(0, 20)) @(negedge clk);
      tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
      wait_tick(1'b0, 2 * p, n);
      lo = 4 * (d + 1) - 1;
      check(n == lo || n == lo + 1, "R6 first load", n, lo);
      repeat (7) @(negedge clk);
      pulse_load();
      wait_tick(1'b0, 2 * p, n);
      check(n == p - 8, "R7 later load", n, p - 8);
    end

    // R8 / R9: receive frames
    d = 9; divv = 5'(d); p = period(d, 0, 0);
    rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
    quiet(1'b1, 300, "R8 idle before start");
    for (int t = 0; t < 2; t++) begin
      rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
      wait_tick(1'b1, 2 * p, n);
      lo = 4 * (d + 1) - 1;
      check(n == lo || n == lo + 1, "R8 start latency", n, lo);
      repeat (5) @(negedge clk);
      pulse_start();
      wait_tick(1'b1, 2 * p, n);
      check(n == p - 6, "R9 start while busy", n, p - 6);
      rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
      @(negedge clk);
      quiet(1'b1, 250, "R9 after done");
    end

    // R2: external pulse source
    foreach (n_ext_list[i]) begin
      ext_per = n_ext_list[i]; sel = 2'd3; divv = 5'd9;
      restart_tx();
      spacing(1'b0, period(9, 3, ext_per), "R2 external");
    end
    ext_per = 0;

    check(dbl == 0, "R11 single-cycle", dbl, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  int n_ext_list [2] = '{5, 7};

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule